// File: doc/BRIEF.md
# Quarter-Rate Digital Upconverter

This block shifts a stream of signed I/Q sample pairs up in frequency by a simple fraction of the sample rate at its own input. The shift is half the sample rate or a quarter of it. Every shift is built from sign changes and I/Q swaps, so the datapath needs no multipliers. A two-bit phase counter sets the rotation step. It moves forward by one on each accepted sample and wraps after four.

A quarter-rate shift can run in complex (image-reject) mode, with a selectable rotation direction, or in real mode. In real mode the in-phase result goes out on both output lanes. There is also a highpass flag for the last interpolation stage. When interpolation is active, this flag negates every odd-phase sample, which mirrors the spectrum about a quarter of the output rate. The configuration inputs are static, and are changed only while no sample is being offered.

Top module: `upconv`

## Requirements
- R1: A sample accepted with `in_valid` high appears on `out_i`/`out_q` with `out_valid` high exactly one clock later. In a cycle after `in_valid` was low, `out_valid` is low and both outputs keep their previous values.
- R2: The phase counter n is 0 after reset. It advances by one modulo 4 on each cycle with `in_valid` high, and on no other cycle.
- R3: With `cfg_shift` = 00 (no shift) and the highpass stage inactive, `out_i` equals the accepted `in_i`.
- R4: With `cfg_shift` = 01 (half-rate shift), the in-phase result is `in_i` multiplied by (-1)^n.
- R5: With `cfg_shift` = 10 or 11 and `cfg_real_mode` = 0, the output is (I + jQ) multiplied by e^(j·d·πn/2). The direction d is +1 when `cfg_rot_pos` XOR (`cfg_shift`==11) is 1, and -1 otherwise. So `cfg_rot_pos` = 0 with shift 10 uses the negative exponent.
- R6: When `cfg_real_mode` = 1, or when `cfg_shift` is 00 or 01, `out_q` equals `out_i`. That value is the in-phase part of the shifted sample, and the complex setting is ignored.
- R7: With `cfg_hpf` = 1 and `cfg_interp` ≠ 00, the shifted result is further multiplied by (-1)^n. With `cfg_interp` = 00, `cfg_hpf` has no effect.
- R8: Every negation saturates: negating the most negative code gives the most positive code. When both the shift and the highpass stage negate a sample, each step saturates in turn.
- R9: During and right after reset, `out_valid`, `out_i` and `out_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DATA_W | Signed in-phase sample |
| in_q | input | DATA_W | Signed quadrature sample |
| cfg_shift | input | 2 | 00 none, 01 half rate, 10 quarter rate, 11 opposite quarter rate |
| cfg_real_mode | input | 1 | 1 real, 0 complex image-reject |
| cfg_rot_pos | input | 1 | 0 negative exponent, 1 positive exponent |
| cfg_interp | input | 2 | 00 1x, 01 2x, 10 4x, 11 8x |
| cfg_hpf | input | 1 | 1 selects highpass last stage |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DATA_W | Shifted in-phase sample |
| out_q | output | DATA_W | Shifted quadrature sample |

## Verification
The bench sweeps all 128 configuration combinations. It carries one running phase count across the whole sweep, and it feeds the most negative and most positive codes. If the rotation direction were inverted, the odd-phase quarter-rate outputs would swap sign. If the shift-11 inversion were missing, shifts 10 and 11 would give the same output. A phase counter that advanced on idle cycles would rotate every later sample by the wrong step. Plain negation of -2048 would wrap back to -2048, and a highpass flag that was honoured at 1x would flip odd samples that must pass unchanged.

// File: rtl/upconv_pkg.sv
package upconv_pkg;
  typedef enum logic [1:0] {
    SHIFT_NONE    = 2'b00,
    SHIFT_HALF    = 2'b01,
    SHIFT_QTR     = 2'b10,
    SHIFT_QTR_ALT = 2'b11
  } shift_e;

  localparam int PHASE_W = 2;
endpackage

// File: rtl/upconv_phase.sv
module upconv_phase
  import upconv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/upconv_rotate.sv
module upconv_rotate
  import upconv_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic [1:0]         shift,
  input  logic               real_mode,
  input  logic               rot_pos,
  input  logic               hpf_en,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] a_q,
  output logic signed [DATA_W-1:0] y_i,
  output logic signed [DATA_W-1:0] y_q
);
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [DATA_W-1:0] sneg(input logic signed [DATA_W-1:0] x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  logic                      dir_pos;
  logic [PHASE_W-1:0]        step;
  logic                      real_eff;
  logic signed [DATA_W-1:0]  r_i, r_q, h_i, h_q;

  always_comb begin
    dir_pos  = rot_pos ^ (shift == SHIFT_QTR_ALT);
    step     = dir_pos ? phase : (PHASE_W'(0) - phase);
    real_eff = real_mode | ~shift[1];
    r_i = a_i;
    r_q = a_q;
    case (shift_e'(shift))
      SHIFT_NONE: begin
        r_i = a_i;
        r_q = a_q;
      end
      SHIFT_HALF: begin
        r_i = phase[0] ? sneg(a_i) : a_i;
        r_q = phase[0] ? sneg(a_q) : a_q;
      end
      default: begin
        case (step)
          2'd0: begin r_i = a_i;       r_q = a_q;       end
          2'd1: begin r_i = sneg(a_q); r_q = a_i;       end
          2'd2: begin r_i = sneg(a_i); r_q = sneg(a_q); end
          default: begin r_i = a_q;    r_q = sneg(a_i); end
        endcase
      end
    endcase
    h_i = (hpf_en && phase[0]) ? sneg(r_i) : r_i;
    h_q = (hpf_en && phase[0]) ? sneg(r_q) : r_q;
    y_i = h_i;
    y_q = real_eff ? h_i : h_q;
  end
endmodule

// File: rtl/upconv.sv
module upconv
  import upconv_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [1:0]               cfg_shift,
  input  logic                     cfg_real_mode,
  input  logic                     cfg_rot_pos,
  input  logic [1:0]               cfg_interp,
  input  logic                     cfg_hpf,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  logic [PHASE_W-1:0]       phase;
  logic                     hpf_en;
  logic signed [DATA_W-1:0] y_i, y_q;

  assign hpf_en = cfg_hpf && (cfg_interp != 2'b00);

  upconv_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .step  (in_valid),
    .phase (phase)
  );

  upconv_rotate #(.DATA_W(DATA_W)) u_rot (
    .phase     (phase),
    .shift     (cfg_shift),
    .real_mode (cfg_real_mode),
    .rot_pos   (cfg_rot_pos),
    .hpf_en    (hpf_en),
    .a_i       (in_i),
    .a_q       (in_q),
    .y_i       (y_i),
    .y_q       (y_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= y_i;
        out_q <= y_q;
      end
    end
  end
endmodule

// File: rtl/upconv_chk.sv
module upconv_chk #(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_i,
  input logic [1:0]               cfg_shift,
  input logic                     cfg_real_mode,
  input logic [1:0]               cfg_interp,
  input logic                     cfg_hpf,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic [1:0]               phase
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q))); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (phase == $past(phase) + 2'd1)); // R2
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase)); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_shift == 2'b00 && !(cfg_hpf && cfg_interp != 2'b00)) |=> (out_i == $past(in_i))); // R3
  AST_REAL_COPY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (cfg_real_mode || !cfg_shift[1])) |=> (out_q == out_i)); // R6
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0)); // R9
endmodule

bind upconv upconv_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_i          (in_i),
  .cfg_shift     (cfg_shift),
  .cfg_real_mode (cfg_real_mode),
  .cfg_interp    (cfg_interp),
  .cfg_hpf       (cfg_hpf),
  .out_valid     (out_valid),
  .out_i         (out_i),
  .out_q         (out_q),
  .phase         (phase)
);

// File: tb/upconv_tb.sv
module upconv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_i = '0, in_q = '0;
  logic [1:0] cfg_shift = 2'b10;
  logic cfg_real_mode = 1'b1;
  logic cfg_rot_pos = 1'b0;
  logic [1:0] cfg_interp = 2'b11;
  logic cfg_hpf = 1'b0;
  logic out_valid;
  logic signed [W-1:0] out_i, out_q;

  int errors = 0;
  int checks = 0;
  int n = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upconv #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_shift(cfg_shift), .cfg_real_mode(cfg_real_mode), .cfg_rot_pos(cfg_rot_pos),
    .cfg_interp(cfg_interp), .cfg_hpf(cfg_hpf),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic int clampv(input int x);
    if (x > MAXV) return MAXV;
    if (x < MINV) return MINV;
    return x;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (n=%0d shift=%0b real=%0b pos=%0b interp=%0b hpf=%0b)",
               req, act, exp, n, cfg_shift, cfg_real_mode, cfg_rot_pos, cfg_interp, cfg_hpf);
    end
  endtask

  // Arithmetic reference: R3 R4 R5 R6 R7 R8
  task automatic model(input int xi, input int xq, input int ph, output int ei, output int eq);
    int c, s, d, sg, ri, rq;
    c  = (ph == 0) ? 1 : (ph == 2) ? -1 : 0;
    s  = (ph == 1) ? 1 : (ph == 3) ? -1 : 0;
    sg = (ph % 2 == 0) ? 1 : -1;
    d  = ((cfg_rot_pos ^ (cfg_shift == 2'b11)) != 0) ? 1 : -1;
    case (cfg_shift)
      2'b00: begin ri = xi; rq = xq; end
      2'b01: begin ri = clampv(xi * sg); rq = clampv(xq * sg); end
      default: begin
        ri = clampv(xi * c - d * xq * s);
        rq = clampv(d * xi * s + xq * c);
      end
    endcase
    if (cfg_hpf && cfg_interp != 2'b00) begin
      ri = clampv(ri * sg);
      rq = clampv(rq * sg);
    end
    ei = ri;
    eq = (cfg_real_mode || !cfg_shift[1]) ? ri : rq;
  endtask

  task automatic send(input int xi, input int xq, input string tag);
    int ei, eq;
    model(xi, xq, n % 4, ei, eq);
    @(negedge clk);
    in_i = W'(xi); in_q = W'(xq); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid", int'(out_valid), 1);
    check({tag, " out_i"}, int'(out_i), ei);
    check({tag, " out_q"}, int'(out_q), eq);
    n++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int xs[8], qs[8];
    int li, lq;
    xs = '{MINV, MAXV, 5, -7, 0, 100, MINV, -1};
    qs = '{3, MINV, MAXV, -9, 11, MINV, MINV, 1};
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", int'(out_valid), 0);
    check("R9 out_i in reset", int'(out_i), 0);
    check("R9 out_q in reset", int'(out_q), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 out_i after reset", int'(out_i), 0);
    for (int cfg = 0; cfg < 128; cfg++) begin
      cfg_shift     = cfg[1:0];
      cfg_real_mode = cfg[2];
      cfg_rot_pos   = cfg[3];
      cfg_interp    = cfg[5:4];
      cfg_hpf       = cfg[6];
      for (int k = 0; k < 5; k++) begin
        int idx;
        idx = (cfg + k) % 8;
        send(xs[idx], qs[idx], "R3 R4 R5 R6 R7 R8 shift");
      end
      li = int'(out_i); lq = int'(out_q);
      repeat (cfg % 3) @(negedge clk);
      @(negedge clk);
      check("R1 idle out_valid", int'(out_valid), 0);
      check("R1 idle hold i", int'(out_i), li);
      check("R2 idle no advance, R1 hold q", int'(out_q), lq);
    end
    // R8 explicit: half-rate odd phase with highpass: -2048 -> 2047 -> -2047
    cfg_shift = 2'b01; cfg_real_mode = 1'b1; cfg_interp = 2'b01; cfg_hpf = 1'b1; cfg_rot_pos = 1'b0;
    if (n % 2 == 0) send(1, 1, "R4 align");
    send(MINV, MINV, "R8 double saturate");
    // R7: highpass ignored at 1x
    cfg_interp = 2'b00;
    if (n % 2 == 0) send(1, 1, "R7 align");
    cfg_shift = 2'b00;
    send(-300, 40, "R7 hpf ignored at 1x");
    // R2: reset returns phase to 0, complex shift at phase 0 passes unchanged
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    n = 0;
    cfg_shift = 2'b10; cfg_real_mode = 1'b0; cfg_hpf = 1'b0;
    send(77, -55, "R2 phase zero after reset");
    send(77, -55, "R2 R5 phase one after reset");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule